// File: doc/BRIEF.md
# Gated Clock Divider with Source Select

This cell derives one divided clock enable for a port from one of several candidate clocks. All candidates are modelled as single-cycle enable pulses on one common fast clock. A single 32-bit control word configures the cell. It chooses which candidate lane drives the divider, sets divide-by-1 or divide-by-10, can power the output down, and can request that the output be held off while the source changes. A write strobe presents each new word. A legal word takes effect at the clock edge that samples the strobe.

The divider counts pulses of the selected lane and emits one registered output pulse at each count boundary. The divide field holds the factor minus one. When the output is enabled, only the values for factors 1 and 10 are accepted. A word with any other divide value is refused and raises a sticky error flag. A source code beyond the candidate set forces the output quiet and also raises the error flag. With automatic blocking requested and a new source chosen, the first two pulses of the new source are swallowed. Counting then resumes from zero.

Top module: `clk_div_cell`

## Requirements
- R1: After reset the output and the error flag are low, the cell is powered down with source code 10 (the 25 MHz reference lane) and divide-by-1, so pulses on any lane produce no output.
- R2: Control word fields: source code in bits 28:24, automatic blocking in bit 11, divide field in bits 5:2 (value 0 = divide by 1, value 9 = divide by 10), power-down in bit 0 (1 = off, 0 = on).
- R3: In divide-by-1 with power-down clear, each pulse on the selected lane gives exactly one output pulse, high during the cycle after the edge that samples the input pulse.
- R4: In divide-by-10, the output fires on the 1st, 11th, 21st ... selected pulse counted from the last accepted write.
- R5: Pulses on lanes other than the selected one are ignored.
- R6: With power-down set, the output stays low.
- R7: A write with power-down clear and a divide field other than 0 or 9 sets the error flag and is not applied: the previous source, divide and counter remain.
- R8: With power-down set, any divide field value is accepted without error.
- R9: A source code of 11 or above keeps the output low and sets the error flag.
- R10: The error flag stays set until reset, including across later legal writes.
- R11: With automatic blocking set and a source code different from the current one, the first two pulses of the new lane give no output and the third does; pulses on the old lane during blocking give no output and are not counted.
- R12: With automatic blocking clear, or with the source code unchanged, no pulses are swallowed after a write.
- R13: A pulse arriving in the same cycle as a write strobe is discarded; after an accepted write the counter restarts, so the next selected pulse gives an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_word_i | input | 32 | Control word |
| src_pulse_i | input | 11 | Candidate clock enable pulses, one lane per source code |
| div_en_o | output | 1 | Divided output enable pulse |
| cfg_err_o | output | 1 | Sticky configuration error flag |

## Verification
A write strobe and a pulse on the selected lane can land in the same cycle, so the configuration reset and the counter advance compete. The bench runs divide-by-10 until the counter sits mid-cycle. It then rewrites the same word while pulsing the selected lane in that very cycle. The output must stay low for that cycle, and the next pulse must fire. That result shows the counter restarted instead of advancing with the old setting.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int SRC_LSB = 24;
  localparam int SRC_W   = 5;
  localparam int AB_BIT  = 11;
  localparam int DIV_LSB = 2;
  localparam int DIV_W   = 4;
  localparam int PD_BIT  = 0;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             autoblk;
    logic             div_ten;
    logic             pd;
  } cdiv_cfg_t;
endpackage

// File: rtl/cdiv_decode.sv
module cdiv_decode
  import clk_div_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DIV_HI  = 10
) (
  input  logic [31:0]      word_i,
  input  logic [SRC_W-1:0] cur_src_i,
  output cdiv_cfg_t        cfg_o,
  output logic             bad_div_o,
  output logic             bad_src_o,
  output logic             blk_start_o
);
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(DIV_HI - 1);
  localparam logic [SRC_W-1:0] SRC_LIM = SRC_W'(NUM_SRC);

  logic [SRC_W-1:0] src;
  logic [DIV_W-1:0] div;
  logic             ab, pd, div_ok;

  always_comb begin
    src    = word_i[SRC_LSB +: SRC_W];
    div    = word_i[DIV_LSB +: DIV_W];
    ab     = word_i[AB_BIT];
    pd     = word_i[PD_BIT];
    div_ok = (div == '0) || (div == DIV_TOP);
    bad_div_o   = !pd && !div_ok;
    bad_src_o   = (src >= SRC_LIM);
    blk_start_o = ab && (src != cur_src_i);
    cfg_o.src     = src;
    cfg_o.autoblk = ab;
    cfg_o.div_ten = (div == DIV_TOP);
    cfg_o.pd      = pd | bad_src_o;  // unknown source behaves as power-down
  end
endmodule

// File: rtl/cdiv_src_mux.sv
module cdiv_src_mux
  import clk_div_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic [SRC_W-1:0]   sel_i,
  output logic               pulse_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    assign hit[i] = src_pulse_i[i] && (sel_i == SRC_W'(i));
  end

  assign pulse_o = |hit;
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int DIV_HI     = 10,
  parameter int BLK_PULSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic apply_i,
  input  logic blk_start_i,
  input  logic div_ten_i,
  input  logic pd_i,
  input  logic pulse_i,
  output logic blk_o,
  output logic div_en_o
);
  localparam int CNT_W = $clog2(DIV_HI);
  localparam int BLK_W = $clog2(BLK_PULSES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DIV_HI - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_PULSES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_max;
  logic [BLK_W-1:0] bcnt_q;
  logic             blk_q, out_q;

  assign cnt_max = div_ten_i ? CNT_TOP : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bcnt_q <= '0;
      blk_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      out_q <= !wr_i && pulse_i && !pd_i && !blk_q && (cnt_q == '0);
      if (apply_i) begin
        cnt_q  <= '0;
        bcnt_q <= '0;
        blk_q  <= blk_start_i;
      end else if (!wr_i && pulse_i) begin
        if (blk_q) begin
          if (bcnt_q == BLK_LAST) blk_q <= 1'b0;
          bcnt_q <= bcnt_q + 1'b1;
        end else if (pd_i || cnt_q == cnt_max) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign blk_o    = blk_q;
  assign div_en_o = out_q;
endmodule

// File: rtl/clk_div_cell.sv
module clk_div_cell
  import clk_div_pkg::*;
#(
  parameter int NUM_SRC    = 11,
  parameter int REF_SRC    = 10,
  parameter int DIV_HI     = 10,
  parameter int BLK_PULSES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [31:0]        cfg_word_i,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  output logic               div_en_o,
  output logic               cfg_err_o
);
  cdiv_cfg_t cfg_q, cfg_new;
  logic      bad_div, bad_src, blk_start, apply, sel_pulse, err_q;
  logic      pd_w, div_ten_w, blk_w;

  cdiv_decode #(.NUM_SRC(NUM_SRC), .DIV_HI(DIV_HI)) u_dec (
    .word_i      (cfg_word_i),
    .cur_src_i   (cfg_q.src),
    .cfg_o       (cfg_new),
    .bad_div_o   (bad_div),
    .bad_src_o   (bad_src),
    .blk_start_o (blk_start)
  );

  assign apply = cfg_wr_i && !bad_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.src     <= SRC_W'(REF_SRC);
      cfg_q.autoblk <= 1'b0;
      cfg_q.div_ten <= 1'b0;
      cfg_q.pd      <= 1'b1;
      err_q         <= 1'b0;
    end else begin
      if (apply) cfg_q <= cfg_new;
      if (cfg_wr_i && (bad_div || bad_src)) err_q <= 1'b1;
    end
  end

  cdiv_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .src_pulse_i (src_pulse_i),
    .sel_i       (cfg_q.src),
    .pulse_o     (sel_pulse)
  );

  assign pd_w      = cfg_q.pd;
  assign div_ten_w = cfg_q.div_ten;

  cdiv_core #(.DIV_HI(DIV_HI), .BLK_PULSES(BLK_PULSES)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (cfg_wr_i),
    .apply_i     (apply),
    .blk_start_i (blk_start),
    .div_ten_i   (div_ten_w),
    .pd_i        (pd_w),
    .pulse_i     (sel_pulse),
    .blk_o       (blk_w),
    .div_en_o    (div_en_o)
  );

  assign cfg_err_o = err_q;
endmodule

// File: rtl/clk_div_cell_chk.sv
module clk_div_cell_chk #(
  parameter int NUM_SRC = 11,
  parameter int DIV_HI  = 10
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_wr_i,
  input logic [31:0] cfg_word_i,
  input logic        div_en_o,
  input logic        cfg_err_o,
  input logic        pd_w,
  input logic        div_ten_w,
  input logic        blk_w
);
  logic wr_bad_div, wr_bad_src;
  assign wr_bad_div = cfg_wr_i && !cfg_word_i[0] &&
                      (cfg_word_i[5:2] != 4'd0) && (cfg_word_i[5:2] != 4'(DIV_HI - 1));
  assign wr_bad_src = cfg_wr_i && (cfg_word_i[28:24] >= 5'(NUM_SRC));

  p_wr_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !div_en_o);
  p_pd_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_w |=> !div_en_o);
  p_blk_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_w |=> !div_en_o);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  p_bad_div_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad_div |=> cfg_err_o);
  p_bad_div_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad_div |=> (div_ten_w == $past(div_ten_w)) && (pd_w == $past(pd_w)));
  p_bad_src_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad_src |=> cfg_err_o);
endmodule

bind clk_div_cell clk_div_cell_chk #(.NUM_SRC(NUM_SRC), .DIV_HI(DIV_HI)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_word_i (cfg_word_i),
  .div_en_o   (div_en_o),
  .cfg_err_o  (cfg_err_o),
  .pd_w       (pd_w),
  .div_ten_w  (div_ten_w),
  .blk_w      (blk_w)
);

// File: tb/tb_clk_div_cell.sv
`timescale 1ns/100ps
module tb_clk_div_cell;
  localparam int NSRC = 11;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [31:0]     cfg_word = '0;
  logic [NSRC-1:0] src_pulse = '0;
  logic            div_en, cfg_err;
  int              errors = 0;
  int              checks = 0;

  always #2.5 clk = ~clk;

  clk_div_cell dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr),
    .cfg_word_i  (cfg_word),
    .src_pulse_i (src_pulse),
    .div_en_o    (div_en),
    .cfg_err_o   (cfg_err)
  );

  function automatic logic [31:0] mk(input int src, input bit ab, input int dv, input bit pd);
    mk = (32'(src) << 24) | (32'(ab) << 11) | (32'(dv) << 2) | 32'(pd);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse(input int lane, input logic exp, input string tag);
    @(negedge clk); src_pulse = '0; src_pulse[lane] = 1'b1;
    @(negedge clk); src_pulse = '0;
    chk(tag, div_en, exp);
  endtask

  task automatic t_reset;
    chk("R1 output after reset", div_en, 1'b0);
    chk("R1 error after reset", cfg_err, 1'b0);
    pulse(10, 1'b0, "R1 reference lane while powered down");
    pulse(3, 1'b0, "R1 other lane while powered down");
  endtask

  task automatic t_div1;
    wr(mk(3, 0, 0, 0));
    for (int k = 0; k < 4; k++) pulse(3, 1'b1, "R3 divide-by-1 pulse");
    pulse(5, 1'b0, "R5 unselected lane ignored");
    pulse(3, 1'b1, "R5 selected lane still counts");
  endtask

  task automatic t_div10;
    wr(mk(3, 0, 9, 0));
    for (int k = 0; k < 25; k++) pulse(3, (k % 10) == 0, "R4 R2 divide-by-10 cadence");
  endtask

  task automatic t_pd;
    wr(mk(3, 0, 0, 1));
    for (int k = 0; k < 3; k++) pulse(3, 1'b0, "R6 power-down output");
    wr(mk(3, 0, 5, 1));
    chk("R8 odd divide with power-down no error", cfg_err, 1'b0);
    pulse(3, 1'b0, "R8 still powered down");
  endtask

  task automatic t_block;
    wr(mk(3, 0, 0, 0));
    pulse(3, 1'b1, "R12 same source no blocking");
    wr(mk(10, 1, 0, 0));
    pulse(10, 1'b0, "R11 first new-source pulse swallowed");
    pulse(3, 1'b0, "R11 old lane during block");
    pulse(10, 1'b0, "R11 second new-source pulse swallowed");
    pulse(10, 1'b1, "R11 third new-source pulse passes");
    wr(mk(4, 0, 0, 0));
    pulse(4, 1'b1, "R12 no autoblock no swallow");
    wr(mk(4, 1, 0, 0));
    pulse(4, 1'b1, "R12 autoblock same source no swallow");
  endtask

  task automatic t_collide;
    wr(mk(4, 0, 9, 0));
    pulse(4, 1'b1, "R4 first pulse after write");
    pulse(4, 1'b0, "R4 second pulse");
    pulse(4, 1'b0, "R4 third pulse");
    @(negedge clk); cfg_wr = 1'b1; cfg_word = mk(4, 0, 9, 0); src_pulse[4] = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; src_pulse = '0;
    chk("R13 pulse in write cycle discarded", div_en, 1'b0);
    pulse(4, 1'b1, "R13 counter restarted");
    pulse(4, 1'b0, "R13 count continues");
  endtask

  task automatic t_errors;
    wr(mk(4, 0, 0, 0));
    chk("R7 no error before illegal divide", cfg_err, 1'b0);
    wr(mk(4, 0, 5, 0));
    chk("R7 illegal divide flags error", cfg_err, 1'b1);
    pulse(4, 1'b1, "R7 previous divide-by-1 kept");
    pulse(4, 1'b1, "R7 previous divide-by-1 kept again");
    wr(mk(20, 0, 0, 0));
    chk("R9 error after bad source", cfg_err, 1'b1);
    for (int l = 0; l < NSRC; l++) pulse(l, 1'b0, "R9 bad source output quiet");
    wr(mk(3, 0, 0, 0));
    chk("R10 error stays after legal write", cfg_err, 1'b1);
    pulse(3, 1'b1, "R10 legal config works");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_div1;
    t_div10;
    t_pd;
    t_block;
    t_collide;
    t_errors;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule